// File: doc/BRIEF.md
# Pin-Configured Serial Receiver

This block is an asynchronous serial receiver for systems that have no processor bus. It watches one serial line, samples it on a clock enable that pulses sixteen times per bit period, and rebuilds a character of 5 to 8 data bits. An optional parity bit is checked after the data bits. The finished character appears on an 8-bit parallel output. Four flags go with it: a character-ready flag, a parity error, a framing error and an overrun error.

The frame format comes from static pins, not from registers. It passes through a configuration latch. While the latch load input is high the latch passes the pins straight through, and while it is low the latch holds the last format. A receiving device, such as a display controller or a data logger, reads the character. It then pulses an active-low acknowledge input to clear the ready flag. Two hide inputs stand in for high-impedance control: one blanks the data output and one blanks the flags, and each is reported on an enable output.

Top module: `pinrx_top`

## Requirements
- R1: The line is sampled only on cycles where `tick16` is high. A low level seen on a tick starts a candidate frame. The start is accepted only if the line is still low 8 ticks later. After that, each data, parity and stop bit is sampled 16 ticks after the previous sample. A low pulse shorter than 8 ticks produces no character.
- R2: `cfg_len` selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits arrive least significant bit first. Output bits above the selected length read 0.
- R3: When `cfg_par_off` is 1, no parity bit is expected and `err_parity` stays 0. When it is 0, one parity bit follows the data. `err_parity` is set when the count of ones in the data plus the parity bit is odd with `cfg_even`=1, or even with `cfg_even`=0.
- R4: `err_frame` is 1 for a character whose sampled stop bit is 0, and 0 when the stop bit is 1.
- R5: `err_overrun` is set when a character completes while `rx_ready` is still 1. It is cleared when a character completes while `rx_ready` is 0.
- R6: `rx_ready` rises one cycle after a character completes. A cycle with `ack_n` low clears it, unless a character completes in that same cycle, in which case it stays 1.
- R7: While `cfg_load` is 1 the configuration pins take effect at once. While it is 0 the format captured on the last cycle with `cfg_load` high is used, and changes on the pins are ignored.
- R8: A cycle with `rst` high clears `rx_ready`, all three error flags and `rx_data`, and returns the receiver to waiting for a start bit.
- R9: With `data_hide` high, `data_en` is 0 and `rx_data` reads 0. With `flag_hide` high, `flag_en` is 0 and all four flags read 0. Hiding does not change the stored values, and they reappear when the hide input is released.
- R10: The data and error flags keep their values until the next character completes, whether or not the character is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, synchronous, active high |
| tick16 | input | 1 | Sampling enable, 16 pulses per bit period |
| rx_in | input | 1 | Serial line, idle high |
| cfg_load | input | 1 | Configuration latch: high passes the pins through, low holds |
| cfg_len | input | 2 | Character length code |
| cfg_par_off | input | 1 | 1 = no parity bit |
| cfg_even | input | 1 | 1 = even parity, 0 = odd parity |
| ack_n | input | 1 | Active-low acknowledge, clears `rx_ready` |
| data_hide | input | 1 | Blanks the data output |
| flag_hide | input | 1 | Blanks the flag outputs |
| rx_data | output | 8 | Received character, zero-extended |
| data_en | output | 1 | High when `rx_data` is driven |
| rx_ready | output | 1 | A character is waiting |
| err_parity | output | 1 | Parity error for the last character |
| err_frame | output | 1 | Framing error for the last character |
| err_overrun | output | 1 | The last character arrived before the previous one was acknowledged |
| flag_en | output | 1 | High when the flags are driven |

## Verification
The receiver is exercised with several kinds of frames:
- 8-bit frames without parity, to show that bit order and the ready handshake are correct.
- 5-bit and 7-bit frames, to show that the length decode and the zero upper bits are correct.
- Frames with correct and wrong parity in both senses, to separate even from odd checking and to show that parity is checked at all.
- A frame with a low stop bit, and two frames in a row with no acknowledge, to exercise the framing and overrun flags.
- A short low glitch, to show that the mid-bit start check rejects noise.
- A frame sent with the latch closed and different pins applied, to show that the latch really holds the format.

// File: rtl/pinrx_pkg.sv
package pinrx_pkg;

    localparam int OVS      = 16;
    localparam int CNT_W    = $clog2(OVS);
    localparam int MAX_BITS = 8;
    localparam int IDX_W    = $clog2(MAX_BITS);

    typedef struct packed {
        logic [1:0] len;
        logic       par_off;
        logic       even;
    } frame_cfg_t;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                perr;
        logic                ferr;
    } rx_result_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_t;

    localparam frame_cfg_t CFG_RESET = '{len: 2'b11, par_off: 1'b1, even: 1'b0};

    function automatic logic [IDX_W-1:0] last_index(input logic [1:0] len);
        return IDX_W'(len) + IDX_W'(4);
    endfunction

    function automatic logic parity_bad(input logic [MAX_BITS-1:0] d,
                                        input logic pbit, input logic even);
        logic x;
        x = ^{d, pbit};
        return even ? x : ~x;
    endfunction

endpackage

// File: rtl/pinrx_cfg_latch.sv
module pinrx_cfg_latch
    import pinrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  frame_cfg_t pins,
    output frame_cfg_t cfg
);
    frame_cfg_t held;

    always_ff @(posedge clk) begin
        if (rst)       held <= CFG_RESET;
        else if (load) held <= pins;
    end

    assign cfg = load ? pins : held;

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(load) && !$past(rst)) |-> $stable(cfg));

endmodule

// File: rtl/pinrx_sampler.sv
module pinrx_sampler
    import pinrx_pkg::*;
#(
    parameter int OVER = OVS,
    localparam int CW  = $clog2(OVER),
    localparam int MID = OVER/2 - 1
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  frame_cfg_t cfg,
    output logic       done,
    output rx_result_t res
);
    rx_state_t           state;
    logic [CW-1:0]       cnt;
    logic [IDX_W-1:0]    idx;
    logic [MAX_BITS-1:0] shreg;
    logic                pbit;
    frame_cfg_t          fcfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
            fcfg  <= CFG_RESET;
            done  <= 1'b0;
            res   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    S_IDLE: if (!rx) begin
                        state <= S_START;
                        cnt   <= '0;
                        shreg <= '0;
                        fcfg  <= cfg;
                    end
                    S_START: begin
                        if (cnt == CW'(MID)) begin
                            cnt   <= '0;
                            idx   <= '0;
                            state <= rx ? S_IDLE : S_DATA;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_DATA: begin
                        if (cnt == CW'(OVER-1)) begin
                            cnt        <= '0;
                            shreg[idx] <= rx;
                            if (idx == last_index(fcfg.len))
                                state <= fcfg.par_off ? S_STOP : S_PAR;
                            else idx <= idx + 1'b1;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_PAR: begin
                        if (cnt == CW'(OVER-1)) begin
                            cnt   <= '0;
                            pbit  <= rx;
                            state <= S_STOP;
                        end else cnt <= cnt + 1'b1;
                    end
                    S_STOP: begin
                        if (cnt == CW'(OVER-1)) begin
                            cnt      <= '0;
                            state    <= S_IDLE;
                            done     <= 1'b1;
                            res.data <= shreg;
                            res.ferr <= !rx;
                            res.perr <= fcfg.par_off ? 1'b0
                                        : parity_bad(shreg, pbit, fcfg.even);
                        end else cnt <= cnt + 1'b1;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R2
    short_word_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fcfg.len == 2'b00) |-> (res.data[7:5] == 3'b000));

    // R1
    start_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_START && tick && cnt == CW'(MID) && rx) |=> (state == S_IDLE));

endmodule

// File: rtl/pinrx_flags.sv
module pinrx_flags
    import pinrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done,
    input  rx_result_t res,
    input  logic       ack_n,
    output logic [MAX_BITS-1:0] data,
    output logic       ready,
    output logic       perr,
    output logic       ferr,
    output logic       ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end else if (done) begin
            data  <= res.data;
            perr  <= res.perr;
            ferr  <= res.ferr;
            ovr   <= ready;
            ready <= 1'b1;
        end else if (!ack_n) begin
            ready <= 1'b0;
        end
    end

    // R6
    ready_set_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);

    // R6
    ready_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !done) |=> !ready);

    // R5
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ready) |=> ovr);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |=> ($stable(data) && $stable(perr) && $stable(ferr)));

endmodule

// File: rtl/pinrx_top.sv
module pinrx_top
    import pinrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rx_in,
    input  logic       cfg_load,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_off,
    input  logic       cfg_even,
    input  logic       ack_n,
    input  logic       data_hide,
    input  logic       flag_hide,
    output logic [7:0] rx_data,
    output logic       data_en,
    output logic       rx_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       flag_en
);
    frame_cfg_t pins, cfg;
    rx_result_t res;
    logic       done;
    logic [MAX_BITS-1:0] d_q;
    logic       rdy_q, pe_q, fe_q, ov_q;

    assign pins = '{len: cfg_len, par_off: cfg_par_off, even: cfg_even};

    pinrx_cfg_latch u_latch (
        .clk(clk), .rst(rst), .load(cfg_load), .pins(pins), .cfg(cfg)
    );

    pinrx_sampler #(.OVER(OVS)) u_samp (
        .clk(clk), .rst(rst), .tick(tick16), .rx(rx_in), .cfg(cfg),
        .done(done), .res(res)
    );

    pinrx_flags u_flags (
        .clk(clk), .rst(rst), .done(done), .res(res), .ack_n(ack_n),
        .data(d_q), .ready(rdy_q), .perr(pe_q), .ferr(fe_q), .ovr(ov_q)
    );

    assign data_en     = !data_hide;
    assign flag_en     = !flag_hide;
    assign rx_data     = data_en ? d_q : '0;
    assign rx_ready    = flag_en & rdy_q;
    assign err_parity  = flag_en & pe_q;
    assign err_frame   = flag_en & fe_q;
    assign err_overrun = flag_en & ov_q;

endmodule

// File: tb/sim_pinrx_top.sv
module sim_pinrx_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16 = 1'b0;
    logic rx_in = 1'b1;
    logic cfg_load = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic cfg_par_off = 1'b1;
    logic cfg_even = 1'b0;
    logic ack_n = 1'b1;
    logic data_hide = 1'b0;
    logic flag_hide = 1'b0;
    logic [7:0] rx_data;
    logic data_en, rx_ready, err_parity, err_frame, err_overrun, flag_en;

    int n_chk = 0;
    int n_bad = 0;
    localparam int BITCLK = 64;

    always #5 clk = ~clk;

    initial forever begin
        @(negedge clk) tick16 = 1'b1;
        @(negedge clk) tick16 = 1'b0;
        @(negedge clk);
        @(negedge clk);
    end

    pinrx_top u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
        .cfg_load(cfg_load), .cfg_len(cfg_len), .cfg_par_off(cfg_par_off),
        .cfg_even(cfg_even), .ack_n(ack_n), .data_hide(data_hide),
        .flag_hide(flag_hide), .rx_data(rx_data), .data_en(data_en),
        .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .flag_en(flag_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit par_en,
                        input bit pbit, input bit stopv);
        rx_in = 1'b0; wait_clk(BITCLK);
        for (int i = 0; i < nb; i++) begin rx_in = d[i]; wait_clk(BITCLK); end
        if (par_en) begin rx_in = pbit; wait_clk(BITCLK); end
        rx_in = stopv; wait_clk(BITCLK);
        rx_in = 1'b1; wait_clk(BITCLK);
    endtask

    task automatic ack();
        ack_n = 1'b0; wait_clk(1); ack_n = 1'b1; wait_clk(1);
    endtask

    task automatic t_reset();
        check("R8 ready", rx_ready, 0);
        check("R8 data", rx_data, 0);
        check("R8 errors", {err_parity, err_frame, err_overrun}, 0);
    endtask

    task automatic t_basic8();
        cfg_len = 2'b11; cfg_par_off = 1'b1;
        send(8'hA5, 8, 0, 0, 1);
        check("R2 data8", rx_data, 8'hA5);
        check("R6 ready set", rx_ready, 1);
        check("R4 good stop", err_frame, 0);
        wait_clk(200);
        check("R10 held", {rx_data, rx_ready}, {8'hA5, 1'b1});
        ack();
        check("R6 ack clears", rx_ready, 0);
        check("R10 data after ack", rx_data, 8'hA5);
    endtask

    task automatic t_len5();
        cfg_len = 2'b00;
        send(8'hF5, 5, 0, 0, 1);
        check("R2 len5 upper zero", rx_data, 8'h15);
        ack();
        cfg_len = 2'b10;
        send(8'h7E, 7, 0, 0, 1);
        check("R2 len7", rx_data, 8'h7E);
        ack();
    endtask

    task automatic t_parity();
        cfg_len = 2'b10; cfg_par_off = 1'b0; cfg_even = 1'b1;
        send(8'h13, 7, 1, 1, 1);
        check("R3 even ok", err_parity, 0);
        ack();
        send(8'h13, 7, 1, 0, 1);
        check("R3 even bad", err_parity, 1);
        ack();
        cfg_even = 1'b0;
        send(8'h13, 7, 1, 0, 1);
        check("R3 odd ok", err_parity, 0);
        check("R3 odd data", rx_data, 8'h13);
        ack();
        cfg_par_off = 1'b1;
    endtask

    task automatic t_frame();
        cfg_len = 2'b11;
        send(8'h3C, 8, 0, 0, 0);
        check("R4 bad stop", err_frame, 1);
        ack();
        send(8'h3D, 8, 0, 0, 1);
        check("R4 cleared", err_frame, 0);
        ack();
    endtask

    task automatic t_overrun();
        send(8'h11, 8, 0, 0, 1);
        check("R5 first no ovr", err_overrun, 0);
        send(8'h22, 8, 0, 0, 1);
        check("R5 overrun", err_overrun, 1);
        check("R5 newest data", rx_data, 8'h22);
        ack();
        send(8'h33, 8, 0, 0, 1);
        check("R5 ovr cleared", err_overrun, 0);
        ack();
    endtask

    task automatic t_glitch();
        rx_in = 1'b0; wait_clk(12); rx_in = 1'b1;
        wait_clk(BITCLK * 12);
        check("R1 glitch ignored", rx_ready, 0);
        check("R1 data unchanged", rx_data, 8'h33);
    endtask

    task automatic t_latch();
        cfg_len = 2'b11; cfg_par_off = 1'b1; wait_clk(2);
        cfg_load = 1'b0; wait_clk(1);
        cfg_len = 2'b00; cfg_par_off = 1'b0;
        send(8'hC3, 8, 0, 0, 1);
        check("R7 held format", rx_data, 8'hC3);
        check("R7 no parity used", err_parity, 0);
        ack();
        cfg_load = 1'b1;
        send(8'h0B, 5, 1, 0, 1);
        check("R7 transparent", rx_data, 8'h0B);
        ack();
        cfg_par_off = 1'b1; cfg_len = 2'b11;
    endtask

    task automatic t_hide();
        send(8'h5A, 8, 0, 0, 0);
        data_hide = 1'b1; flag_hide = 1'b1; wait_clk(1);
        check("R9 data hidden", {data_en, rx_data}, 0);
        check("R9 flags hidden", {flag_en, rx_ready, err_frame}, 0);
        data_hide = 1'b0; flag_hide = 1'b0; wait_clk(1);
        check("R9 restored", {data_en, rx_data, flag_en, rx_ready, err_frame},
              {1'b1, 8'h5A, 1'b1, 1'b1, 1'b1});
        ack();
    endtask

    task automatic t_rst();
        send(8'h77, 8, 0, 0, 0);
        rst = 1'b1; wait_clk(2); rst = 1'b0; wait_clk(2);
        check("R8 mid-run reset", {rx_data, rx_ready, err_frame}, 0);
    endtask

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_basic8();
        t_len5();
        t_parity();
        t_frame();
        t_overrun();
        t_glitch();
        t_latch();
        t_hide();
        t_rst();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule